// File: doc/BRIEF.md
# Toroidal Life Generation Stepper

This block holds a two-state cellular-automaton board and advances it by one generation on request. The board is stored as words of 64 cells, several words per row, and the engine updates a whole word per clock: for the word under work it gathers the rows above, at and below it, forms the left- and right-shifted copies of each, and runs a bitwise neighbour counter across all 64 lanes at once. Neighbours wrap in both directions, so the board behaves as a torus.

Two equal storage banks are used. One bank (the front) is the board the host sees and the engine reads; the engine writes the next generation into the other bank (the back), and the roles swap when the last word has been written. A host port loads and reads the front bank while the engine is idle. A one-cycle start request launches a generation; a one-cycle done pulse reports that the swap has happened.

Top module: `life_stepper`

## Requirements
- R1: A cell is live in the next generation when exactly 3 of its 8 neighbours are live, or when exactly 2 are live and the cell itself is live; in every other case it is dead.
- R2: Word address a holds row a / WORDS_PER_ROW, word column a % WORDS_PER_ROW; bit b of that word is cell column 64 * (word column) + b. host_rdata returns the front-bank word at host_addr combinationally, and a host write while idle lands in that word.
- R3: The row above row 0 is the last row, and the row below the last row is row 0.
- R4: Within a row, cell bit 63 of one word and cell bit 0 of the next word are horizontal neighbours.
- R5: The last cell of a row (bit 63 of its last word) and the first cell of the same row (bit 0 of its first word) are horizontal neighbours.
- R6: Every cell of a new generation is computed from the previous generation only; no result is visible to the host before the bank swap.
- R7: After start is sampled high while idle, busy is high for exactly ROWS*WORDS_PER_ROW cycles, then done is high for exactly one cycle with busy low, in the cycle right after the swap.
- R8: A start level while busy is ignored: the generation neither restarts nor runs twice.
- R9: A host write while busy is ignored and does not change the generation being computed.
- R10: After reset every cell of both banks is dead and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one generation (sampled while idle) |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle pulse after the bank swap |
| host_we | input | 1 | Host write strobe to the front bank |
| host_addr | input | ADDR_W | Host word address, 0 to ROWS*WORDS_PER_ROW-1 |
| host_wdata | input | 64 | Host write word |
| host_rdata | output | 64 | Front-bank word at host_addr |

## Verification
A wrong word index, wrong wrap arithmetic or a swapped shift direction corrupts only the cells that sit on a row edge, word edge or board edge, so the bench places small oscillators across each of those seams and compares every word of the board against an independent per-cell model once done has fired. A faulty sequencer shows at once on busy and done, which are compared against the expected level on every clock of a run, including runs where start is held high and where the host tries to write mid-generation; a corrupted front word then shows in the result of the same generation.

// File: rtl/life_pkg.sv
package life_pkg;

    localparam int LANES = 64;

    typedef logic [LANES-1:0] lane_t;

    // Nine neighbourhood words, ordered top-left ... bottom-right.
    typedef struct packed {
        lane_t tl;
        lane_t t;
        lane_t tr;
        lane_t l;
        lane_t c;
        lane_t r;
        lane_t bl;
        lane_t b;
        lane_t br;
    } nbhd_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } step_state_t;

    function automatic int wrap_dec(input int v, input int lim);
        return (v == 0) ? lim - 1 : v - 1;
    endfunction

    function automatic int wrap_inc(input int v, input int lim);
        return (v == lim - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/life_row_shift.sv
// Builds the left, centre and right views of one row word; the bit that
// crosses a word edge comes from the adjacent word of the same row.
module life_row_shift
    import life_pkg::*;
(
    input  lane_t cur_w,
    input  logic  prev_msb,
    input  logic  next_lsb,
    output lane_t lft,
    output lane_t ctr,
    output lane_t rgt
);
    // lft[b] is the cell at column b-1, rgt[b] the cell at column b+1
    assign lft = {cur_w[LANES-2:0], prev_msb};
    assign ctr = cur_w;
    assign rgt = {next_lsb, cur_w[LANES-1:1]};
endmodule

// File: rtl/life_lane_rule.sv
// Bitwise neighbour counter and survival rule across all lanes.
module life_lane_rule
    import life_pkg::*;
(
    input  nbhd_t nb,
    output lane_t nxt
);
    lane_t ring [8];
    lane_t s0, s1, hi, c0, c1;

    assign ring[0] = nb.tl;
    assign ring[1] = nb.t;
    assign ring[2] = nb.tr;
    assign ring[3] = nb.l;
    assign ring[4] = nb.r;
    assign ring[5] = nb.bl;
    assign ring[6] = nb.b;
    assign ring[7] = nb.br;

    // Chain of half adders: s1:s0 counts modulo 4, hi is sticky for >= 4.
    always_comb begin
        s0 = '0;
        s1 = '0;
        hi = '0;
        c0 = '0;
        c1 = '0;
        for (int i = 0; i < 8; i++) begin
            c0 = s0 & ring[i];
            s0 = s0 ^ ring[i];
            c1 = s1 & c0;
            s1 = s1 ^ c0;
            hi = hi | c1;
        end
    end

    // count 3 -> live; count 2 -> keep centre
    assign nxt = ~hi & s1 & (s0 | nb.c);
endmodule

// File: rtl/life_step_ctrl.sv
module life_step_ctrl
    import life_pkg::*;
#(
    parameter int NWORDS = 16,
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          sel,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    step_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            idx  <= '0;
            sel  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_RUN;
                        idx <= '0;
                    end
                end
                ST_RUN: begin
                    if (idx == LAST) begin
                        st   <= ST_IDLE;
                        sel  <= ~sel;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st == ST_RUN);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_swap_only_at_done_R6: assert property (@(posedge clk) disable iff (rst)
        (sel != $past(sel)) |-> done);

    assert_walk_ignores_start_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == $past(idx) + IW'(1)));
endmodule

// File: rtl/life_stepper.sv
module life_stepper
    import life_pkg::*;
#(
    parameter int ROWS          = 8,
    parameter int WORDS_PER_ROW = 2,
    localparam int NWORDS = ROWS * WORDS_PER_ROW,
    localparam int ADDR_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata
);
    lane_t             bank [2][NWORDS];
    logic              sel;
    logic [ADDR_W-1:0] idx;
    lane_t             nxt;
    nbhd_t             nb;

    lane_t             cur_w   [3];
    logic              prev_b  [3];
    logic              next_b  [3];
    lane_t             v_lft   [3];
    lane_t             v_ctr   [3];
    lane_t             v_rgt   [3];

    function automatic logic [ADDR_W-1:0] waddr(input int r, input int c);
        return ADDR_W'(r * WORDS_PER_ROW + c);
    endfunction

    life_step_ctrl #(.NWORDS(NWORDS)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .sel   (sel),
        .idx   (idx)
    );

    // Fetch the three rows around the word under work, with torus wrap.
    always_comb begin
        int row, col, cl, cr;
        int rows_k [3];
        row = int'(idx) / WORDS_PER_ROW;
        col = int'(idx) % WORDS_PER_ROW;
        cl  = wrap_dec(col, WORDS_PER_ROW);
        cr  = wrap_inc(col, WORDS_PER_ROW);
        rows_k[0] = wrap_dec(row, ROWS);
        rows_k[1] = row;
        rows_k[2] = wrap_inc(row, ROWS);
        for (int k = 0; k < 3; k++) begin
            cur_w[k]  = bank[sel][waddr(rows_k[k], col)];
            prev_b[k] = bank[sel][waddr(rows_k[k], cl)][LANES-1];
            next_b[k] = bank[sel][waddr(rows_k[k], cr)][0];
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_row
        life_row_shift u_shift (
            .cur_w    (cur_w[k]),
            .prev_msb (prev_b[k]),
            .next_lsb (next_b[k]),
            .lft      (v_lft[k]),
            .ctr      (v_ctr[k]),
            .rgt      (v_rgt[k])
        );
    end

    always_comb begin
        nb.tl = v_lft[0];
        nb.t  = v_ctr[0];
        nb.tr = v_rgt[0];
        nb.l  = v_lft[1];
        nb.c  = v_ctr[1];
        nb.r  = v_rgt[1];
        nb.bl = v_lft[2];
        nb.b  = v_ctr[2];
        nb.br = v_rgt[2];
    end

    life_lane_rule u_rule (
        .nb  (nb),
        .nxt (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int w = 0; w < NWORDS; w++)
                    bank[b][w] <= '0;
        end else begin
            if (busy)
                bank[~sel][idx] <= nxt;
            else if (host_we)
                bank[sel][host_addr] <= host_wdata;
        end
    end

    assign host_rdata = bank[sel][host_addr];

    // The front bank must hold still for the whole generation.
    assert_front_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bank[sel][host_addr]) || $changed(host_addr));
endmodule

// File: tb/tb_life_stepper.sv
module tb_life_stepper;
    localparam int CLK_P  = 10;
    localparam int ROWS   = 8;
    localparam int WPR    = 2;
    localparam int COLS   = WPR * 64;
    localparam int NW     = ROWS * WPR;
    localparam int AW     = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          busy;
    logic          done;
    logic          host_we;
    logic [AW-1:0] host_addr;
    logic [63:0]   host_wdata;
    logic [63:0]   host_rdata;

    int checks = 0;
    int errors = 0;
    bit grid [ROWS][COLS];

    always #(CLK_P/2) clk = ~clk;

    life_stepper #(.ROWS(ROWS), .WORDS_PER_ROW(WPR)) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_word(input int a);
        logic [63:0] w;
        int r = a / WPR;
        int c = a % WPR;
        for (int b = 0; b < 64; b++) w[b] = grid[r][c*64 + b];
        return w;
    endfunction

    function automatic void model_step();
        bit nx [ROWS][COLS];
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                int n = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (dr != 0 || dc != 0)
                            n += grid[(r+dr+ROWS)%ROWS][(c+dc+COLS)%COLS];
                nx[r][c] = (n == 3) || (n == 2 && grid[r][c]);
            end
        grid = nx;
    endfunction

    function automatic void clear_grid();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) grid[r][c] = 1'b0;
    endfunction

    task automatic load_board();
        for (int a = 0; a < NW; a++) begin
            @(negedge clk);
            host_we    = 1'b1;
            host_addr  = AW'(a);
            host_wdata = model_word(a);
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic compare_board(input string req);
        @(negedge clk);
        for (int a = 0; a < NW; a++) begin
            host_addr = AW'(a);
            #1;
            chk(host_rdata === model_word(a), req, $sformatf("word %0d", a),
                host_rdata, model_word(a));
        end
    endtask

    // One generation with per-clock checks of busy and done.
    task automatic run_gen(input bit hold_start, input bit poke, input string req);
        @(negedge clk);
        start = 1'b1;
        for (int k = 1; k <= NW; k++) begin
            @(negedge clk);
            if (!hold_start || k >= NW - 1) start = 1'b0;
            if (poke && k == 2) begin
                host_we    = 1'b1;
                host_addr  = AW'(NW - 1);
                host_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
            end
            if (k == 3) host_we = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R7",
                $sformatf("running cycle %0d busy/done", k), {busy, done}, 2'b10);
        end
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R7", "done pulse", {busy, done}, 2'b01);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, hold_start ? "R8" : "R7",
            "idle after done", {busy, done}, 2'b00);
        model_step();
        compare_board(req);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; host_we = 1'b0;
        host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk(busy === 1'b0 && done === 1'b0, "R10", "busy/done after reset",
            {busy, done}, 2'b00);
        clear_grid();
        compare_board("R10");

        // R1, R2: blinker in the middle of a word
        clear_grid();
        grid[3][30] = 1; grid[3][31] = 1; grid[3][32] = 1;
        load_board();
        compare_board("R2");
        run_gen(1'b0, 1'b0, "R1");
        run_gen(1'b0, 1'b0, "R1");

        // R3: vertical blinker across the top/bottom seam
        clear_grid();
        grid[7][10] = 1; grid[0][10] = 1; grid[1][10] = 1;
        load_board();
        run_gen(1'b0, 1'b0, "R3");
        run_gen(1'b0, 1'b0, "R3");

        // R4: blinker across the word seam inside a row
        clear_grid();
        grid[4][63] = 1; grid[4][64] = 1; grid[4][65] = 1;
        load_board();
        run_gen(1'b0, 1'b0, "R4");
        run_gen(1'b0, 1'b0, "R4");

        // R5: blinker across the row end
        clear_grid();
        grid[5][127] = 1; grid[5][0] = 1; grid[5][1] = 1;
        load_board();
        run_gen(1'b0, 1'b0, "R5");
        run_gen(1'b0, 1'b0, "R5");

        // R1, R6, R8, R9: random soup over several generations
        clear_grid();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                grid[r][c] = (($urandom % 3) == 0);
        load_board();
        compare_board("R2");
        run_gen(1'b0, 1'b0, "R6");
        run_gen(1'b1, 1'b0, "R8");
        run_gen(1'b0, 1'b1, "R9");
        run_gen(1'b0, 1'b0, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule